// File: doc/BRIEF.md
# Inter-Core Mailbox Queues

This block lets a group of cores exchange short messages without going through shared memory. Every core owns one small receive queue. Any core can place a 64-bit message into the queue of any core, including its own. Only the owning core can take messages out of its own queue.

A sender presents a destination number, a data word and a valid flag. It keeps all three steady while its stall output is high. When several senders aim at the same queue in one cycle, a round-robin arbiter picks one of them. A sender whose target queue is full waits, stalled, until a slot frees up.

Each owner sees the message at the head of its queue, a non-empty flag and an entry count. It removes the head with a one-cycle pop strobe. No other agent, including any management processor, has a port into the fabric.

Top module: `mbox_fabric`

## Requirements
- R1: Each queue holds up to DEPTH (default 4) entries of DATA_W (default 64) bits. `rcv_count` of a queue reports its occupancy, from 0 to DEPTH. `rcv_nonempty` is high exactly when that count is non-zero.
- R2: A send from any core with destination ID d (bits [s*3+2:s*3] of `snd_dest`) is appended to queue d. Once the send is accepted, the count of queue d rises by one on that clock edge.
- R3: A pop on queue d (`rcv_pop[d]`) changes only queue d. A pop on an empty queue has no effect: the count stays 0.
- R4: `snd_stall[s]` is high in a cycle exactly when `snd_valid[s]` is high and the send is not taken at the next rising edge. A send is accepted at the first rising edge where its stall is low.
- R5: While a queue holds DEPTH entries and is not popped, every sender to it is stalled. A push and a pop on a full queue in the same cycle are both accepted, and the count stays at DEPTH.
- R6: At most one push enters a queue per cycle. Among competing senders, the first requester at or above the priority pointer wins, counting upward with wrap. The pointer starts at core 0 after reset and moves to one past the core whose push was accepted.
- R7: Messages from one sender to one destination come out of that queue in the order they were sent.
- R8: After reset, every queue is empty and every stall output is low while no send is valid.
- R9: Sends to different destinations in the same cycle are all accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| snd_valid | input | N_CORES | Per-sender request |
| snd_dest | input | N_CORES*ID_W | Per-sender destination ID; sender s uses bits [s*ID_W +: ID_W] |
| snd_data | input | N_CORES*DATA_W | Per-sender message word |
| snd_stall | output | N_CORES | Per-sender stall; the send is held while high |
| rcv_pop | input | N_CORES | Per-owner pop strobe |
| rcv_data | output | N_CORES*DATA_W | Head entry of each queue |
| rcv_nonempty | output | N_CORES | Queue holds at least one entry |
| rcv_count | output | N_CORES*CNT_W | Queue occupancy |

## Verification
The bench first sends single messages and streams from one sender to one queue, which separates routing errors from ordering errors. It then fills a queue and holds an extra sender against it. This shows that the stall holds while the queue is full and that the stall drops in the very cycle a pop frees a slot. Two rounds of three-way contention for one queue, started from different pointer positions, reveal whether the grant order truly rotates or stays fixed. Sends to disjoint queues in the same cycle, and pops on empty or foreign queues, check that queues do not affect one another.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   parameter int unsigned DEF_CORES  = 8;
   parameter int unsigned DEF_DATA_W = 64;
   parameter int unsigned DEF_DEPTH  = 4;

   function automatic int unsigned cnt_bits(input int unsigned depth);
      return $clog2(depth + 1);
   endfunction
endpackage

// File: rtl/mbox_rr_arb.sv
module mbox_rr_arb #(
   parameter int unsigned N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic         adv,
   output logic [N-1:0] grant
);
   localparam int unsigned IDX_W = $clog2(N);

   if (N < 2) begin : g_bad
      $error("mbox_rr_arb needs at least two requesters");
   end

   logic [IDX_W-1:0] ptr, gidx;

   always_comb begin
      grant = '0;
      gidx  = '0;
      for (int i = 0; i < int'(N); i++) begin
         logic [IDX_W-1:0] kk;
         kk = IDX_W'((int'(ptr) + i) % int'(N));
         if (grant == '0 && req[kk]) begin
            grant[kk] = 1'b1;
            gidx      = kk;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr <= '0;
      else if (adv && grant != '0)
         ptr <= (gidx == IDX_W'(N - 1)) ? '0 : gidx + 1'b1;
   end

   assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   assert_grant_in_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~req) == '0);
   assert_grant_when_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0) |-> (grant != '0));
endmodule

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned CNT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic [CNT_W-1:0]  count
);
   localparam int unsigned PTR_W = $clog2(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("mbox_fifo depth must be at least 2");
   end
   if (CNT_W < $clog2(DEPTH + 1)) begin : g_bad_cnt
      $error("mbox_fifo count width too small");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wptr, rptr;
   logic              pop_ok;

   assign pop_ok = pop && (count != '0);
   assign head   = mem[rptr];

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push)   wptr <= bump(wptr);
         if (pop_ok) rptr <= bump(rptr);
         count <= count + CNT_W'(push) - CNT_W'(pop_ok);
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wptr] <= wdata;
   end

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (count < CNT_W'(DEPTH) || pop));
   assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
   assert_empty_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && !push) |=> count == '0);
endmodule

// File: rtl/mbox_fabric.sv
module mbox_fabric
   import mbox_pkg::*;
#(
   parameter int unsigned N_CORES = DEF_CORES,
   parameter int unsigned DATA_W  = DEF_DATA_W,
   parameter int unsigned DEPTH   = DEF_DEPTH,
   parameter int unsigned ID_W    = $clog2(DEF_CORES),
   parameter int unsigned CNT_W   = cnt_bits(DEF_DEPTH)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [N_CORES-1:0]          snd_valid,
   input  logic [N_CORES*ID_W-1:0]     snd_dest,
   input  logic [N_CORES*DATA_W-1:0]   snd_data,
   output logic [N_CORES-1:0]          snd_stall,
   input  logic [N_CORES-1:0]          rcv_pop,
   output logic [N_CORES*DATA_W-1:0]   rcv_data,
   output logic [N_CORES-1:0]          rcv_nonempty,
   output logic [N_CORES*CNT_W-1:0]    rcv_count
);
   if (N_CORES < 2 || N_CORES > (1 << ID_W)) begin : g_bad_cores
      $error("mbox_fabric: N_CORES must be 2..2**ID_W");
   end
   if (CNT_W < $clog2(DEPTH + 1)) begin : g_bad_cnt
      $error("mbox_fabric: CNT_W too narrow for DEPTH");
   end

   logic [N_CORES-1:0] req    [N_CORES];
   logic [N_CORES-1:0] grant  [N_CORES];
   logic [N_CORES-1:0] accept;
   logic [N_CORES-1:0] full;
   logic [N_CORES-1:0] acc;

   for (genvar d = 0; d < int'(N_CORES); d++) begin : g_dst
      logic [DATA_W-1:0] pdata;
      logic [CNT_W-1:0]  cnt;

      for (genvar s = 0; s < int'(N_CORES); s++) begin : g_req
         assign req[d][s] = snd_valid[s] && (snd_dest[s*ID_W +: ID_W] == ID_W'(d));
      end

      mbox_rr_arb #(.N(N_CORES)) u_arb (
         .clk(clk), .rst_n(rst_n), .req(req[d]), .adv(accept[d]), .grant(grant[d])
      );

      assign full[d]   = (cnt == CNT_W'(DEPTH));
      assign accept[d] = (grant[d] != '0) && (!full[d] || rcv_pop[d]);

      always_comb begin
         pdata = '0;
         for (int s = 0; s < int'(N_CORES); s++)
            if (grant[d][s]) pdata = snd_data[s*DATA_W +: DATA_W];
      end

      mbox_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_q (
         .clk(clk), .rst_n(rst_n), .push(accept[d]), .wdata(pdata),
         .pop(rcv_pop[d]), .head(rcv_data[d*DATA_W +: DATA_W]), .count(cnt)
      );

      assign rcv_count[d*CNT_W +: CNT_W] = cnt;
      assign rcv_nonempty[d]             = (cnt != '0);
   end

   always_comb begin
      acc = '0;
      for (int d = 0; d < int'(N_CORES); d++)
         acc = acc | (grant[d] & {N_CORES{accept[d]}});
   end

   assign snd_stall = snd_valid & ~acc;

   for (genvar s = 0; s < int'(N_CORES); s++) begin : g_chk
      logic [ID_W-1:0] dst;
      assign dst = snd_dest[s*ID_W +: ID_W];
      assert_stall_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
         snd_stall[s] |-> snd_valid[s]);
      assert_full_stalls_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (snd_valid[s] && full[dst] && !rcv_pop[dst]) |-> snd_stall[s]);
   end
endmodule

// File: tb/mbox_fabric_tb.sv
module mbox_fabric_tb;
   localparam int N = 8, W = 64, IDW = 3, CW = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [N-1:0]     snd_valid, snd_stall, rcv_pop, rcv_nonempty;
   logic [N*IDW-1:0] snd_dest;
   logic [N*W-1:0]   snd_data, rcv_data;
   logic [N*CW-1:0]  rcv_count;

   logic          sv [N];
   logic [IDW-1:0] sd [N];
   logic [W-1:0]  sx [N];
   logic          rp [N];
   logic [W-1:0]  expq [N][$];
   int nchk = 0, nfail = 0;

   always #2 clk = ~clk;

   always_comb
      for (int i = 0; i < N; i++) begin
         snd_valid[i]           = sv[i];
         snd_dest[i*IDW +: IDW] = sd[i];
         snd_data[i*W +: W]     = sx[i];
         rcv_pop[i]             = rp[i];
      end

   mbox_fabric u_dut (.*);

   task automatic chk(input bit ok, input string rq, input logic [W-1:0] act, input logic [W-1:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic send(input int s, input int d, input logic [W-1:0] x);
      @(negedge clk);
      sv[s] = 1'b1; sd[s] = IDW'(d); sx[s] = x;
      #1;
      while (snd_stall[s]) begin @(negedge clk); #1; end
      expq[d].push_back(x);
      @(posedge clk); #1;
      sv[s] = 1'b0;
   endtask

   task automatic pop_chk(input int d, input string rq);
      logic [W-1:0] e;
      @(negedge clk);
      rp[d] = 1'b1;
      #1;
      e = (expq[d].size() != 0) ? expq[d].pop_front() : '1;
      chk(rcv_nonempty[d] === 1'b1, rq, W'(rcv_nonempty[d]), 1);
      chk(rcv_data[d*W +: W] === e, rq, rcv_data[d*W +: W], e);
      @(posedge clk); #1;
      rp[d] = 1'b0;
   endtask

   task automatic cnt_chk(input int d, input string rq);
      @(negedge clk); #1;
      chk(rcv_count[d*CW +: CW] == CW'(expq[d].size()), rq,
          W'(rcv_count[d*CW +: CW]), W'(expq[d].size()));
      chk(rcv_nonempty[d] == (expq[d].size() != 0), {rq, " R1"},
          W'(rcv_nonempty[d]), W'(expq[d].size() != 0));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nfail++; nchk++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) begin sv[i] = 0; sd[i] = 0; sx[i] = 0; rp[i] = 0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R8: reset state
      @(negedge clk); #1;
      chk(rcv_count == '0, "R8 count", W'(rcv_count), 0);
      chk(rcv_nonempty == '0, "R8 nonempty", W'(rcv_nonempty), 0);
      chk(snd_stall == '0, "R8 stall", W'(snd_stall), 0);

      // R2: single message routed to its destination
      send(0, 5, 64'h0123_4567_89ab_cdef);
      cnt_chk(5, "R2 count");
      pop_chk(5, "R2 data");

      // R7: ordered stream from one sender
      for (int k = 0; k < 3; k++) send(3, 6, 64'hA000 + 64'(k));
      cnt_chk(6, "R7 count");
      for (int k = 0; k < 3; k++) pop_chk(6, "R7 order");

      // R1 / R5: fill, stall, push+pop on full
      for (int k = 0; k < 4; k++) send(1, 0, 64'hF000 + 64'(k));
      cnt_chk(0, "R1 full count");
      fork
         send(2, 0, 64'hF0F0);
         begin
            repeat (3) begin
               @(negedge clk); #1;
               chk(snd_stall[2] === 1'b1, "R5 stall while full", W'(snd_stall[2]), 1);
            end
            pop_chk(0, "R5 pop on full");
         end
      join
      cnt_chk(0, "R5 count after push+pop");
      for (int k = 0; k < 4; k++) pop_chk(0, "R5 drain");

      // R6: round robin, pointer from 0
      fork
         send(1, 3, 64'hB1);
         send(2, 3, 64'hB2);
         send(5, 3, 64'hB5);
         begin
            @(negedge clk); #1;
            chk(snd_stall == 8'b0010_0100, "R6 first grant core1", W'(snd_stall), 64'h24);
         end
      join
      cnt_chk(3, "R6 count");
      for (int k = 0; k < 3; k++) pop_chk(3, "R6 order round1");
      // pointer now at 6: expected order 6,0,2
      fork
         send(0, 3, 64'hC0);
         send(2, 3, 64'hC2);
         send(6, 3, 64'hC6);
         begin
            @(negedge clk); #1;
            chk(snd_stall == 8'b0000_0101, "R6 rotated grant core6", W'(snd_stall), 64'h05);
         end
      join
      for (int k = 0; k < 3; k++) pop_chk(3, "R6 order round2");

      // R9: disjoint destinations accepted together
      fork
         send(4, 1, 64'hD4);
         send(7, 2, 64'hD7);
         begin
            @(negedge clk); #1;
            chk(snd_stall == '0, "R9 no stall", W'(snd_stall), 0);
         end
      join
      cnt_chk(1, "R9 count q1");
      cnt_chk(2, "R9 count q2");

      // R3: pop on empty and on another queue
      @(negedge clk); rp[6] = 1'b1; rp[2] = 1'b1;
      @(posedge clk); #1; rp[6] = 1'b0; rp[2] = 1'b0;
      void'(expq[2].pop_front());
      cnt_chk(6, "R3 empty pop");
      cnt_chk(1, "R3 foreign pop");
      pop_chk(1, "R3 data intact");
      send(6, 6, 64'hE6);
      pop_chk(6, "R3 after empty pop");

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule